// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a byte-wide flash device and turns completed bus writes into decisions. Each accepted write carries an address and a data byte. While no sequence is open, the data byte is read as a command code. The block keeps track of which kind of data a read returns (array contents, identifier codes or the status byte). It opens and closes two-cycle sequences. When a sequence, or a single-cycle command that needs the write engine, completes with permission, it hands exactly one operation request to a separate write state machine.

Permission depends on three things: the lock bit of the block being addressed, the device-wide master lock bit, and an input that reports reset held at elevated voltage. The lock bits themselves belong to the storage array, so they arrive here as inputs. A refused operation does not reach the write engine. It sets a status error flag instead. A malformed confirm byte also sets an error flag, and it closes the sequence.

Both data paths use valid/ready. Inbound writes are taken on any clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` stays low while a request is waiting, so only one request is ever outstanding. An outbound request moves on an edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the request and all of its fields stay unchanged.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read mode is array (`read_mode` = 0), both error flags are 0 and no request is pending. In idle, code FFh returns the mode to array.
- R2: In idle, code 90h sets identifier mode (`read_mode` = 1) and 70h sets status mode (`read_mode` = 2). The chosen mode holds across later writes that do not select another mode.
- R3: Code 50h in idle clears both `seq_err` and `perm_err` and leaves `read_mode` unchanged.
- R4: Code 20h followed by D0h issues an erase request (`req_op` = 0) that carries the address and data of the confirm write. Afterwards the mode is status.
- R5: Setup code 40h and setup code 10h behave identically. The next write of any data issues a program request (`req_op` = 1) carrying that write's address and data. Afterwards the mode is status.
- R6: In idle, B0h issues a suspend request (`req_op` = 2) and D0h issues a resume request (`req_op` = 3). Each is a single write, and each sets status mode.
- R7: After setup code 60h, the confirm byte selects the operation: 01h gives set-block-lock (`req_op` = 4), F1h gives set-master-lock (`req_op` = 5) and D0h gives clear-all-block-locks (`req_op` = 6).
- R8: An erase or program aimed at a block whose lock bit is set is refused unless `hv_reset` is high. Refusal sets `perm_err` and issues no request. The block index is address bits [BLK_LSB +: log2(NUM_BLK)].
- R9: Set-master-lock needs `hv_reset` high. Set-block-lock and clear-all-block-locks need `hv_reset` high only while `master_lock` is set. Otherwise each is refused as in R8.
- R10: A confirm byte other than D0h after 20h, or other than 01h/F1h/D0h after 60h, issues no request, sets `seq_err` and selects status mode.
- R11: In idle, any code not named in R1 to R7 is ignored: the read mode and the error flags keep their values.
- R12: While `req_valid` is high, `wr_ready` is low. While `req_ready` is low, `req_valid`, `req_op`, `req_addr` and `req_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Completed write strobe is presented |
| wr_ready | output | 1 | Decoder can take a write |
| wr_addr | input | ADDR_W | Address captured with the write |
| wr_data | input | DATA_W | Data byte captured with the write |
| hv_reset | input | 1 | Reset pin is at elevated voltage |
| blk_lock | input | NUM_BLK | Per-block lock bits from the array |
| master_lock | input | 1 | Device-wide master lock bit |
| read_mode | output | 2 | 0 array, 1 identifier, 2 status |
| seq_err | output | 1 | Command-sequence error flag |
| perm_err | output | 1 | Lock-permission refusal flag |
| req_valid | output | 1 | Operation request pending |
| req_ready | input | 1 | Write engine accepts the request |
| req_op | output | 3 | Operation code, see R4 to R7 |
| req_addr | output | ADDR_W | Target address |
| req_data | output | DATA_W | Data of the final write |

## Verification
The bench builds the block with ADDR_W=16, NUM_BLK=4 and BLK_LSB=14. With these values the block index is the top two address bits, so chosen addresses reach both locked and unlocked blocks. A stalling `req_ready` pattern, plus a forced long stall, exercises the back-pressure rules against a scoreboard of expected requests. The lock inputs and `hv_reset` are driven through every combination that the permission rules separate.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [1:0] {MODE_ARRAY = 2'd0, MODE_IDENT = 2'd1, MODE_STATUS = 2'd2} rmode_t;
  typedef enum logic [2:0] {
    OP_ERASE = 3'd0, OP_PROG = 3'd1, OP_SUSP = 3'd2, OP_RESUME = 3'd3,
    OP_LOCK_BLK = 3'd4, OP_LOCK_MASTER = 3'd5, OP_UNLOCK_ALL = 3'd6
  } op_t;
  typedef enum logic [1:0] {S_IDLE, S_ERASE, S_PROG, S_LOCK} seq_t;

  localparam logic [7:0] C_ARRAY   = 8'hFF;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_CLRSTAT = 8'h50;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_PROG_A  = 8'h40;
  localparam logic [7:0] C_PROG_B  = 8'h10;
  localparam logic [7:0] C_LOCKSET = 8'h60;
  localparam logic [7:0] C_SUSP    = 8'hB0;
  localparam logic [7:0] C_GO      = 8'hD0;
  localparam logic [7:0] C_BLKBIT  = 8'h01;
  localparam logic [7:0] C_MSTBIT  = 8'hF1;
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [7:0] wdata,
  input  logic       perm_ok,
  output logic       cand_valid,
  output op_t        cand_op,
  output rmode_t     mode,
  output logic       seq_err,
  output logic       perm_err
);
  seq_t   st, st_n;
  rmode_t mode_n;
  logic   bad_cfm, clr_err;

  always_comb begin
    st_n       = st;
    mode_n     = mode;
    cand_valid = 1'b0;
    cand_op    = OP_SUSP;
    bad_cfm    = 1'b0;
    clr_err    = 1'b0;
    unique case (st)
      S_IDLE: begin
        unique case (wdata)
          C_ARRAY:            mode_n = MODE_ARRAY;
          C_IDENT:            mode_n = MODE_IDENT;
          C_STATUS:           mode_n = MODE_STATUS;
          C_CLRSTAT:          clr_err = 1'b1;
          C_ERASE:            st_n = S_ERASE;
          C_PROG_A, C_PROG_B: st_n = S_PROG;
          C_LOCKSET:          st_n = S_LOCK;
          C_SUSP: begin cand_valid = 1'b1; cand_op = OP_SUSP;   mode_n = MODE_STATUS; end
          C_GO:   begin cand_valid = 1'b1; cand_op = OP_RESUME; mode_n = MODE_STATUS; end
          default: ;
        endcase
      end
      S_ERASE: begin
        st_n = S_IDLE; mode_n = MODE_STATUS;
        if (wdata == C_GO) begin cand_valid = 1'b1; cand_op = OP_ERASE; end
        else bad_cfm = 1'b1;
      end
      S_PROG: begin
        st_n = S_IDLE; mode_n = MODE_STATUS;
        cand_valid = 1'b1; cand_op = OP_PROG;
      end
      default: begin
        st_n = S_IDLE; mode_n = MODE_STATUS;
        unique case (wdata)
          C_BLKBIT: begin cand_valid = 1'b1; cand_op = OP_LOCK_BLK;    end
          C_MSTBIT: begin cand_valid = 1'b1; cand_op = OP_LOCK_MASTER; end
          C_GO:     begin cand_valid = 1'b1; cand_op = OP_UNLOCK_ALL;  end
          default:  bad_cfm = 1'b1;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; mode <= MODE_ARRAY; seq_err <= 1'b0; perm_err <= 1'b0;
    end else if (fire) begin
      st   <= st_n;
      mode <= mode_n;
      if (clr_err) begin
        seq_err <= 1'b0; perm_err <= 1'b0;
      end
      if (bad_cfm) seq_err <= 1'b1;
      if (cand_valid && !perm_ok) perm_err <= 1'b1;
    end
  end

  // R1
  array_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && st == S_IDLE && wdata == 8'hFF |=> mode == MODE_ARRAY);
  // R10
  bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && st == S_ERASE && wdata != 8'hD0 |=> seq_err && mode == MODE_STATUS);
  // R11
  unknown_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && st == S_IDLE && wdata == 8'h33 |=> $stable(mode) && $stable(seq_err) && $stable(perm_err));
endmodule

// File: rtl/fcd_perm.sv
module fcd_perm
  import fcd_pkg::*;
(
  input  op_t  op,
  input  logic blk_locked,
  input  logic master_lock,
  input  logic hv_reset,
  output logic ok
);
  always_comb begin
    unique case (op)
      OP_ERASE, OP_PROG:          ok = !blk_locked || hv_reset;
      OP_LOCK_BLK, OP_UNLOCK_ALL: ok = !master_lock || hv_reset;
      OP_LOCK_MASTER:             ok = hv_reset;
      default:                    ok = 1'b1;
    endcase
  end
endmodule

// File: rtl/fcd_req.sv
module fcd_req
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  op_t               op_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              req_ready,
  output logic              req_valid,
  output op_t               req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0; req_op <= OP_SUSP; req_addr <= '0; req_data <= '0;
    end else if (load) begin
      req_valid <= 1'b1; req_op <= op_in; req_addr <= addr_in; req_data <= data_in;
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_addr) && $stable(req_data));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 8,
  parameter int NUM_BLK = 16,
  parameter int BLK_LSB = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               hv_reset,
  input  logic [NUM_BLK-1:0] blk_lock,
  input  logic               master_lock,
  output logic [1:0]         read_mode,
  output logic               seq_err,
  output logic               perm_err,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [2:0]         req_op,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [DATA_W-1:0]  req_data
);
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;

  logic             fire, cand_valid, perm_ok, blk_locked;
  op_t              cand_op, op_q;
  rmode_t           mode_q;
  logic [BLK_W-1:0] blk_idx;

  assign wr_ready   = !req_valid;
  assign fire       = wr_valid && wr_ready;
  assign blk_idx    = wr_addr[BLK_LSB +: BLK_W];
  assign blk_locked = blk_lock[blk_idx];

  fcd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .wdata(wr_data[7:0]), .perm_ok(perm_ok),
    .cand_valid(cand_valid), .cand_op(cand_op), .mode(mode_q),
    .seq_err(seq_err), .perm_err(perm_err)
  );

  fcd_perm u_perm (
    .op(cand_op), .blk_locked(blk_locked), .master_lock(master_lock),
    .hv_reset(hv_reset), .ok(perm_ok)
  );

  fcd_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_n), .load(fire && cand_valid && perm_ok),
    .op_in(cand_op), .addr_in(wr_addr), .data_in(wr_data), .req_ready(req_ready),
    .req_valid(req_valid), .req_op(op_q), .req_addr(req_addr), .req_data(req_data)
  );

  assign req_op    = op_q;
  assign read_mode = mode_q;

  // R8
  locked_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cand_valid && (cand_op == OP_ERASE || cand_op == OP_PROG) && blk_locked && !hv_reset
    |=> !req_valid && perm_err);
  // R9
  master_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cand_valid && cand_op == OP_LOCK_MASTER && !hv_reset |=> !req_valid && perm_err);
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int AW = 16;
  logic clk = 0, rst_n = 0, wr_valid = 0, hv_reset = 0, master_lock = 0, req_ready = 0;
  logic [AW-1:0] wr_addr = '0, req_addr;
  logic [7:0] wr_data = '0, req_data;
  logic [3:0] blk_lock = 4'b0100;
  logic wr_ready, seq_err, perm_err, req_valid;
  logic [1:0] read_mode;
  logic [2:0] req_op;
  int checks = 0, bad = 0, cyc = 0;
  bit hold = 0, done = 0;
  logic [26:0] expq[$];

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(8), .NUM_BLK(4), .BLK_LSB(14)) u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .hv_reset(hv_reset), .blk_lock(blk_lock), .master_lock(master_lock),
    .read_mode(read_mode), .seq_err(seq_err), .perm_err(perm_err), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr), .req_data(req_data));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_addr = a; wr_data = d; wr_valid = 1;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic expect_req(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    expq.push_back({op, a, d});
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && (expq.size() != 0 || req_valid); i++) @(negedge clk);
    chk(expq.size() == 0, "drain", expq.size(), 0);
  endtask

  task automatic errs(input logic s, input logic p, input string tag);
    chk(seq_err == s && perm_err == p, tag, {seq_err, perm_err}, {s, p});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    req_ready = hold ? 1'b0 : (cyc % 3 != 0);
    if (req_valid && req_ready) begin
      if (expq.size() == 0) chk(0, "unexpected request", {req_op, req_addr, req_data}, 0);
      else begin
        logic [26:0] e;
        e = expq.pop_front();
        chk({req_op, req_addr, req_data} == e, "request R4-R7 scoreboard", {req_op, req_addr, req_data}, e);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(read_mode == 0 && !req_valid && wr_ready, "R1 reset", read_mode, 0);
    errs(0, 0, "R1 reset errors");
    // R2 modes
    wr(16'h0000, 8'h90); chk(read_mode == 1, "R2 ident", read_mode, 1);
    // R11 unknown ignored
    wr(16'h1234, 8'h33); chk(read_mode == 1, "R11 ignore", read_mode, 1);
    errs(0, 0, "R11 errors kept");
    wr(16'h0000, 8'h70); chk(read_mode == 2, "R2 status", read_mode, 2);
    wr(16'h0000, 8'h5A); chk(read_mode == 2, "R2 holds", read_mode, 2);
    wr(16'h0000, 8'hFF); chk(read_mode == 0, "R1 array", read_mode, 0);
    // R4 erase
    wr(16'h4010, 8'h20); chk(read_mode == 0, "R4 setup keeps mode", read_mode, 0);
    expect_req(3'd0, 16'h4020, 8'hD0);
    wr(16'h4020, 8'hD0); chk(read_mode == 2, "R4 status after erase", read_mode, 2);
    drain();
    // R5 program, both setups
    wr(16'h0000, 8'h40); expect_req(3'd1, 16'h0123, 8'h5A); wr(16'h0123, 8'h5A); drain();
    wr(16'h0000, 8'hFF);
    wr(16'h0000, 8'h10); expect_req(3'd1, 16'hC001, 8'hA5); wr(16'hC001, 8'hA5);
    chk(read_mode == 2, "R5 status after program", read_mode, 2);
    drain();
    // R6 suspend / resume
    wr(16'h0000, 8'hFF);
    expect_req(3'd2, 16'h0007, 8'hB0); wr(16'h0007, 8'hB0);
    chk(read_mode == 2, "R6 suspend status", read_mode, 2);
    drain();
    expect_req(3'd3, 16'h0009, 8'hD0); wr(16'h0009, 8'hD0); drain();
    // R7 lock operations, master clear
    wr(16'h4000, 8'h60); expect_req(3'd4, 16'h4000, 8'h01); wr(16'h4000, 8'h01); drain();
    wr(16'h0000, 8'h60); expect_req(3'd6, 16'h0000, 8'hD0); wr(16'h0000, 8'hD0); drain();
    hv_reset = 1;
    wr(16'h0000, 8'h60); expect_req(3'd5, 16'h0002, 8'hF1); wr(16'h0002, 8'hF1); drain();
    hv_reset = 0;
    errs(0, 0, "R7 no errors");
    // R8 locked block (index 2)
    wr(16'h8000, 8'h20); wr(16'h8001, 8'hD0);
    chk(!req_valid, "R8 erase refused", req_valid, 0);
    errs(0, 1, "R8 perm_err");
    wr(16'h0000, 8'h50); errs(0, 0, "R3 clear");
    chk(read_mode == 2, "R3 mode kept", read_mode, 2);
    wr(16'h0000, 8'h40); wr(16'h9000, 8'h11);
    chk(!req_valid, "R8 program refused", req_valid, 0);
    errs(0, 1, "R8 program perm_err");
    wr(16'h0000, 8'h50);
    hv_reset = 1;
    wr(16'h0000, 8'h40); expect_req(3'd1, 16'h9000, 8'h11); wr(16'h9000, 8'h11); drain();
    errs(0, 0, "R8 hv allows");
    hv_reset = 0;
    // R9 master lock set
    master_lock = 1;
    wr(16'h0000, 8'h60); wr(16'h0000, 8'h01);
    chk(!req_valid, "R9 block lock refused", req_valid, 0);
    errs(0, 1, "R9 perm_err set-block");
    wr(16'h0000, 8'h50);
    wr(16'h0000, 8'h60); wr(16'h0000, 8'hD0);
    errs(0, 1, "R9 perm_err clear-all");
    wr(16'h0000, 8'h50);
    wr(16'h0000, 8'h60); wr(16'h0000, 8'hF1);
    errs(0, 1, "R9 master needs hv");
    wr(16'h0000, 8'h50);
    hv_reset = 1;
    wr(16'h0000, 8'h60); expect_req(3'd4, 16'h0000, 8'h01); wr(16'h0000, 8'h01); drain();
    errs(0, 0, "R9 hv permits");
    hv_reset = 0; master_lock = 0;
    // R10 bad confirm
    wr(16'h0000, 8'hFF); wr(16'h0000, 8'h20); wr(16'h0000, 8'h55);
    chk(read_mode == 2 && !req_valid, "R10 erase abort", read_mode, 2);
    errs(1, 0, "R10 seq_err");
    wr(16'h0000, 8'h50); wr(16'h0000, 8'hFF);
    wr(16'h0000, 8'h60); wr(16'h0000, 8'h77);
    chk(read_mode == 2, "R10 lock abort mode", read_mode, 2);
    errs(1, 0, "R10 lock seq_err");
    wr(16'h0000, 8'h50);
    // R12 back-pressure
    hold = 1;
    expect_req(3'd2, 16'h0042, 8'hB0); wr(16'h0042, 8'hB0);
    chk(req_valid && !wr_ready, "R12 wr_ready low", wr_ready, 0);
    repeat (3) @(negedge clk);
    chk(req_valid && req_op == 3'd2 && req_addr == 16'h0042, "R12 held", req_addr, 16'h0042);
    hold = 0;
    drain();
    chk(wr_ready, "R12 ready again", wr_ready, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule